// File: doc/BRIEF.md
# Condition-Register Fail-First Vector Length Truncation

This unit walks the elements of a vectorised condition-register operation one per accepted cycle. For each element it tests one bit of the element's result. Evaluation stops at the first element whose test fails. At that point the vector length is cut down, and the element either counts toward the shortened length or does not, depending on the mode. Each element that survives the test is given a commit enable, which allows the downstream register-file write to go ahead.

A `start` pulse loads the configuration and the starting vector length. The configuration holds a 2-bit truncation selector, a polarity bit, a 2-bit field-bit selector and an operand-width flag. The operand-width flag chooses between two cases. One is an instruction whose result is a single condition bit. The other is an instruction whose result is a whole 4-bit condition field, from which the selector picks one bit. Element results then arrive from upstream with `elemValid`. The unit ends with a one-cycle `done` pulse, and `vlOut` carries the resulting length.

Top module: `cr_ff_trunc`

## Requirements
- R1: During and after reset, `busy`, `done` and `commitEn` are low and `vlOut` is 0.
- R2: `start` is accepted only when the unit is neither running nor signalling done. It latches all configuration inputs and `vlIn`. A `start` during a run has no effect on that run's result.
- R3: When `cfgFive`=1 the tested bit is `elemBit` and `elemField` is ignored. When `cfgFive`=0 the tested bit is taken from `elemField`, where `elemField[3..0]` holds LT, GT, EQ and SO in that order. `cfgSel` picks the bit: 0 selects LT (bit 3), 1 selects GT (bit 2), 2 selects EQ (bit 1) and 3 selects SO (bit 0).
- R4: With `cfgInv`=0 a test passes when the tested bit is 1. With `cfgInv`=1 it passes when the bit is 0.
- R5: With `cfgMode`=2'b01, a failing element at index i gives `vlOut`=i and gets no commit enable.
- R6: With `cfgMode`=2'b10, a failing element at index i gives `vlOut`=i+1 and does get a commit enable.
- R7: After the first failing element no further element is taken. `busy` drops in the following cycle.
- R8: If every element passes, all VL elements are committed and `vlOut` equals the starting VL.
- R9: With `cfgMode` 2'b00 or 2'b11 no test can fail. Every element is committed and `vlOut` equals the starting VL.
- R10: A running cycle with `elemValid` low produces no commit enable and leaves `elemIdx` unchanged.
- R11: `done` is high for exactly one cycle, the cycle after the final element is taken. `vlOut` holds its value from then until the next run ends.
- R12: A starting VL of 0 ends the run in the first running cycle without consuming an element. `vlOut` is 0 and no commit enable is issued.
- R13: While running, `elemIdx` gives the index of the element currently expected, counting from 0 and rising by one per accepted passing element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; configuration and length are latched |
| cfgMode | input | 2 | Truncation selector: 01 excludes, 10 includes the failing element, other codes disable truncation |
| cfgInv | input | 1 | Test polarity |
| cfgSel | input | 2 | Bit selector into a 4-bit result field |
| cfgFive | input | 1 | 1: single-bit result, 0: 4-bit field result |
| vlIn | input | VLW (7) | Starting vector length |
| elemValid | input | 1 | An element result is present this cycle |
| elemBit | input | 1 | Single-bit result of the element |
| elemField | input | 4 | Field result of the element (LT, GT, EQ, SO from bit 3 down) |
| busy | output | 1 | Run in progress, elements accepted |
| elemIdx | output | VLW (7) | Index of the element expected |
| commitEn | output | 1 | Element result may be written |
| done | output | 1 | One-cycle end-of-run pulse |
| vlOut | output | VLW (7) | Resulting vector length |

## Verification
The hardest condition to reach is a failure on the very last element when the failing element is included. Here the truncated length equals the original length, so the result looks exactly like a run with no failure. The table therefore places a field result that fails on index VL-1 in inclusive mode and checks the commit mask alongside the length.

Two other situations cannot occur in an orderly stream, so the bench forces them. One is a `start` arriving mid-run. The other is a bubble on `elemValid`. The bench injects both inside one run and checks that the index and the final length do not change.

// File: rtl/cr_ff_pkg.sv
package cr_ff_pkg;
  localparam logic [1:0] FF_CUT_EXCL = 2'b01;
  localparam logic [1:0] FF_CUT_INCL = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} ffState_e;

  typedef struct packed {
    logic load;
    logic step;
    logic cutExcl;
    logic cutIncl;
    logic keepFull;
  } ffStrobe_t;
endpackage

// File: rtl/cr_ff_dp.sv
module cr_ff_dp
  import cr_ff_pkg::*;
#(
  parameter int VLW = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  ffStrobe_t      strobe,
  input  logic [1:0]     cfgMode,
  input  logic           cfgInv,
  input  logic [1:0]     cfgSel,
  input  logic           cfgFive,
  input  logic [VLW-1:0] vlIn,
  input  logic           elemBit,
  input  logic [3:0]     elemField,
  output logic           failNow,
  output logic           inclMode,
  output logic           lastElem,
  output logic           vlZero,
  output logic [VLW-1:0] elemIdx,
  output logic [VLW-1:0] vlOut
);
  logic [1:0]     modeQ;
  logic           invQ;
  logic [1:0]     selQ;
  logic           fiveQ;
  logic [VLW-1:0] vlQ;
  logic [VLW-1:0] idxQ;
  logic [VLW-1:0] vlOutQ;
  logic           fieldBit;
  logic           testBit;
  logic           ffActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= '0;
      invQ   <= 1'b0;
      selQ   <= '0;
      fiveQ  <= 1'b0;
      vlQ    <= '0;
      idxQ   <= '0;
      vlOutQ <= '0;
    end else begin
      if (strobe.load) begin
        modeQ <= cfgMode;
        invQ  <= cfgInv;
        selQ  <= cfgSel;
        fiveQ <= cfgFive;
        vlQ   <= vlIn;
        idxQ  <= '0;
      end else if (strobe.step) begin
        idxQ <= idxQ + 1'b1;
      end
      if (strobe.cutExcl)       vlOutQ <= idxQ;
      else if (strobe.cutIncl)  vlOutQ <= idxQ + 1'b1;
      else if (strobe.keepFull) vlOutQ <= vlQ;
    end
  end

  // selector 0 picks the top bit (LT), 3 the bottom bit (SO)
  assign fieldBit = elemField[2'd3 - selQ];
  assign testBit  = fiveQ ? elemBit : fieldBit;
  assign ffActive = (modeQ == FF_CUT_EXCL) || (modeQ == FF_CUT_INCL);
  assign failNow  = ffActive && ((testBit ^ invQ) == 1'b0);
  assign inclMode = (modeQ == FF_CUT_INCL);
  assign vlZero   = (vlQ == '0);
  assign lastElem = (idxQ == (vlQ - {{(VLW-1){1'b0}}, 1'b1}));
  assign elemIdx  = idxQ;
  assign vlOut    = vlOutQ;
endmodule

// File: rtl/cr_ff_ctrl.sv
module cr_ff_ctrl
  import cr_ff_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      elemValid,
  input  logic      failNow,
  input  logic      inclMode,
  input  logic      lastElem,
  input  logic      vlZero,
  output ffStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      commitEn
);
  ffState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateD      = S_RUN;
        end
      end
      S_RUN: begin
        if (vlZero) begin
          strobe.keepFull = 1'b1;
          stateD          = S_DONE;
        end else if (elemValid) begin
          if (failNow) begin
            strobe.cutIncl = inclMode;
            strobe.cutExcl = !inclMode;
            stateD         = S_DONE;
          end else if (lastElem) begin
            strobe.keepFull = 1'b1;
            stateD          = S_DONE;
          end else begin
            strobe.step = 1'b1;
          end
        end
      end
      S_DONE:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  assign busy     = (stateQ == S_RUN);
  assign done     = (stateQ == S_DONE);
  assign commitEn = busy && elemValid && !vlZero && (!failNow || inclMode);
endmodule

// File: rtl/cr_ff_trunc.sv
module cr_ff_trunc
  import cr_ff_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW = $clog2(MAX_VL + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [1:0]     cfgMode,
  input  logic           cfgInv,
  input  logic [1:0]     cfgSel,
  input  logic           cfgFive,
  input  logic [VLW-1:0] vlIn,
  input  logic           elemValid,
  input  logic           elemBit,
  input  logic [3:0]     elemField,
  output logic           busy,
  output logic [VLW-1:0] elemIdx,
  output logic           commitEn,
  output logic           done,
  output logic [VLW-1:0] vlOut
);
  ffStrobe_t strobe;
  logic      failNow;
  logic      inclMode;
  logic      lastElem;
  logic      vlZero;

  cr_ff_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .elemValid(elemValid),
    .failNow(failNow), .inclMode(inclMode), .lastElem(lastElem),
    .vlZero(vlZero), .strobe(strobe), .busy(busy), .done(done),
    .commitEn(commitEn)
  );

  cr_ff_dp #(.VLW(VLW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgMode(cfgMode),
    .cfgInv(cfgInv), .cfgSel(cfgSel), .cfgFive(cfgFive), .vlIn(vlIn),
    .elemBit(elemBit), .elemField(elemField), .failNow(failNow),
    .inclMode(inclMode), .lastElem(lastElem), .vlZero(vlZero),
    .elemIdx(elemIdx), .vlOut(vlOut)
  );
endmodule

// File: rtl/cr_ff_checker.sv
module cr_ff_checker #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           elemValid,
  input logic           commitEn,
  input logic           done,
  input logic [VLW-1:0] vlOut,
  input logic [VLW-1:0] elemIdx,
  input logic           failNow,
  input logic           inclMode,
  input logic           vlZero
);
  assert_commit_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    commitEn |-> (busy && elemValid));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !elemValid) |=> (elemIdx == $past(elemIdx)));

  assert_excl_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && elemValid && !vlZero && failNow && !inclMode) |-> !commitEn);

  assert_incl_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && elemValid && !vlZero && failNow && inclMode) |-> commitEn);

  assert_stop_after_fail_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && elemValid && !vlZero && failNow) |=> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_follows_run_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  assert_vl_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(vlOut));

  assert_idx_step_R13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && elemValid && !vlZero && !failNow) |=>
      (!busy || (elemIdx == $past(elemIdx) + 1'b1)));
endmodule

bind cr_ff_trunc cr_ff_checker #(.VLW(VLW)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .elemValid(elemValid),
  .commitEn(commitEn), .done(done), .vlOut(vlOut), .elemIdx(elemIdx),
  .failNow(failNow), .inclMode(inclMode), .vlZero(vlZero)
);

// File: tb/tb_cr_ff_trunc.sv
module tb_cr_ff_trunc;
  localparam int VLW = 7;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [1:0]     cfgMode = '0;
  logic           cfgInv = 1'b0;
  logic [1:0]     cfgSel = '0;
  logic           cfgFive = 1'b0;
  logic [VLW-1:0] vlIn = '0;
  logic           elemValid = 1'b0;
  logic           elemBit = 1'b0;
  logic [3:0]     elemField = '0;
  logic           busy;
  logic [VLW-1:0] elemIdx;
  logic           commitEn;
  logic           done;
  logic [VLW-1:0] vlOut;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cr_ff_trunc dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode),
    .cfgInv(cfgInv), .cfgSel(cfgSel), .cfgFive(cfgFive), .vlIn(vlIn),
    .elemValid(elemValid), .elemBit(elemBit), .elemField(elemField),
    .busy(busy), .elemIdx(elemIdx), .commitEn(commitEn), .done(done),
    .vlOut(vlOut)
  );

  // {mode, five, inv, sel, vl, data (nibble k = element k), expVl, expMask}
  localparam logic [53:0] VECS [0:7] = '{
    {2'b01, 1'b1, 1'b0, 2'd0, 4'd5, 32'h00000011, 4'd2, 8'b00000011},
    {2'b10, 1'b1, 1'b0, 2'd0, 4'd5, 32'h00000011, 4'd3, 8'b00000111},
    {2'b01, 1'b1, 1'b1, 2'd0, 4'd4, 32'h00000000, 4'd4, 8'b00001111},
    {2'b01, 1'b0, 1'b0, 2'd2, 4'd6, 32'h00FFF832, 4'd2, 8'b00000011},
    {2'b10, 1'b0, 1'b1, 2'd0, 4'd4, 32'h00008370, 4'd4, 8'b00001111},
    {2'b01, 1'b0, 1'b0, 2'd3, 4'd3, 32'h00000FF0, 4'd0, 8'b00000000},
    {2'b11, 1'b1, 1'b0, 2'd0, 4'd4, 32'h00000000, 4'd4, 8'b00001111},
    {2'b10, 1'b0, 1'b0, 2'd1, 4'd8, 32'hB4444444, 4'd8, 8'b11111111}
  };
  string tags [0:7] = '{"R3 R5", "R3 R6", "R4 R8", "R3 R5",
                        "R4 R6", "R5", "R9", "R6 R8"};

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runElems(input logic [1:0] m, input logic f, input logic inv,
                          input logic [1:0] s, input int vl, input logic [31:0] data,
                          input int stallAt, input int midStartAt,
                          output logic [7:0] mask);
    int k;
    int guard;
    bit stalled;
    logic [VLW-1:0] idxHeld;
    k = 0; guard = 0; stalled = 0; mask = '0;
    @(negedge clk);
    start = 1'b1; cfgMode = m; cfgFive = f; cfgInv = inv; cfgSel = s;
    vlIn = VLW'(vl);
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 40) begin
      guard++;
      if (k == stallAt && !stalled) begin
        stalled = 1;
        elemValid = 1'b0;
        #1;
        chk(!commitEn, "R10 commit on bubble", commitEn, 0);
        idxHeld = elemIdx;
        @(negedge clk);
        chk(elemIdx == idxHeld, "R10 index after bubble", elemIdx, idxHeld);
      end else begin
        if (k == midStartAt) begin
          start = 1'b1; vlIn = 7'd7; cfgMode = 2'b01; cfgSel = 2'd3;
        end
        elemValid = 1'b1;
        elemField = data[4*(k%8) +: 4];
        elemBit   = data[4*(k%8)];
        #1;
        chk(elemIdx == VLW'(k), "R13 elemIdx", elemIdx, k);
        mask[k%8] = commitEn;
        @(negedge clk);
        elemValid = 1'b0; start = 1'b0;
        k++;
      end
    end
    chk(done, "R7 R11 done after last element", done, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] mask;
    logic [VLW-1:0] held;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !commitEn, "R1 controls in reset", {busy, done, commitEn}, 0);
    chk(vlOut == '0, "R1 vlOut in reset", vlOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !commitEn && vlOut == '0, "R1 after reset",
        {busy, done, commitEn}, 0);

    for (int n = 0; n < 8; n++) begin
      logic [53:0] v;
      v = VECS[n];
      runElems(v[53:52], v[51], v[50], v[49:48], int'(v[47:44]), v[43:12], -1, -1, mask);
      chk(vlOut == VLW'(v[11:8]), tags[n], vlOut, v[11:8]);
      chk(mask == v[7:0], tags[n], mask, v[7:0]);
      held = vlOut;
      @(negedge clk);
      chk(!done && vlOut == held, "R11 pulse ends, vlOut held", done, 0);
    end

    // R12: zero length
    runElems(2'b01, 1'b1, 1'b0, 2'd0, 0, 32'h0, -1, -1, mask);
    chk(vlOut == '0, "R12 vlOut", vlOut, 0);
    chk(mask == '0, "R12 no commit", mask, 0);

    // R2 and R10: bubble at index 1, ignored start at index 2
    runElems(2'b10, 1'b1, 1'b0, 2'd0, 3, 32'h00000111, 1, 2, mask);
    chk(vlOut == 7'd3, "R2 R10 vlOut", vlOut, 3);
    chk(mask == 8'b00000111, "R2 R10 commit mask", mask, 7);

    // R11: ignored start during done does not begin a run
    runElems(2'b01, 1'b1, 1'b0, 2'd0, 2, 32'h00000001, -1, -1, mask);
    start = 1'b1; vlIn = 7'd5;
    @(negedge clk);
    start = 1'b0;
    chk(!busy, "R2 start during done ignored", busy, 0);
    chk(vlOut == 7'd1, "R5 vlOut held", vlOut, 1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule